// File: doc/BRIEF.md
# Dual-Channel Register-Programmed PWM Generator

This peripheral produces two independent pulse-width-modulated outputs, each shaped by its own prescaler, period and duty setting held in a small bank of memory-mapped registers. Software writes a channel's registers through a plain read/write port. Every write first lands in a readable holding copy. It then passes through a short fixed-delay transfer stage before the counting logic is allowed to use it. A shared status word shows, per channel and per register, which writes are still in that transfer stage. Software polls it before issuing the next write.

Each channel counts input clocks in a prescaler and, on each prescaler rollover, advances a period counter. The output is asserted at the start of every period and drops once the period counter passes the duty value. With the autoload bit clear, new settings take effect as soon as they arrive. With autoload set on a running channel, they are held back until the period boundary, so a change never produces a malformed pulse. The control register also selects output inversion, and it chooses between a graceful stop at the end of the period and an immediate one.

Top module: `dual_pwm`

## Requirements
- R1: Channel n's registers occupy byte offsets n*0x10 + {0x0 control, 0x4 prescale, 0x8 period, 0xC duty}. A read returns the last value written, masked to the field width (control 6 bits, prescale 10 bits, period 12 bits, duty 12 bits). Offsets of the two unused channel slots (0x20 to 0x3F) read as zero, and writes to them are ignored.
- R2: The status register at offset 0x40 holds four pending bits per channel: bit 0 control, bit 1 prescale, bit 2 period, bit 3 duty. Channel n's bits are shifted left by 8*n. A bit reads as 1 from the first clock edge that accepts a write to its register.
- R3: A pending bit stays set for exactly two clock cycles after the write, unless another write to the same register arrives, and then clears. On the cycle it clears, the written value has reached the counting logic.
- R4: Status bits that are not defined always read as zero. A write to offset 0x40 changes nothing.
- R5: An enabled channel (control bit 0) starts a new period with its output asserted. The period lasts (prescale+1)*(period+1) input clocks. The output is high for (prescale+1)*duty clocks when duty is less than period.
- R6: With duty greater than or equal to period, the output stays high continuously. With duty 0 and a nonzero period, it stays low.
- R7: Control bit 1 complements the output, including the idle level. A stopped channel idles low when bit 1 is clear and high when it is set.
- R8: With control bit 2 (autoload) clear, a new prescale, period or duty value takes effect when its transfer completes. With bit 2 set on a running channel, new values take effect only at the next period boundary.
- R9: With autoload set, a control write with bit 4 set forces the transferred prescale into use as soon as that control write completes. Bit 5 does the same for the period value.
- R10: Clearing control bit 0 with bit 3 clear lets the current period run to its end. The channel then idles.
- R11: Clearing control bit 0 with bit 3 (stop immediately) set idles the output on the cycle after the control transfer completes.
- R12: The two channels count and drive their outputs independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock for registers and counters |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe; write accepted on the rising clock edge |
| bus_addr | input | 7 | Byte address of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational from the address |
| pwm_out | output | 2 | One PWM output per channel |

## Verification
On every cycle, the assertions check several properties. A write raises its pending bit on the next edge. A clearing pending bit coincides with the transferred copy matching the written value. A channel always starts with zeroed counters. A run ends only at a period boundary or on an immediate stop. With autoload set, the active period holds steady between boundaries. The status read never shows undefined bits. Several behaviours can only be shown by the bench scenarios: the measured high time and period length for several settings, the inverted and full-on/full-off waveforms, the visible difference between immediate and deferred loading, the forced load, and the exact cycle on which an immediate stop idles the output.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int unsigned CTRL_W      = 6;
  localparam int unsigned REG_CNT     = 4;
  localparam int unsigned STAT_STRIDE = 8;

  // register index inside a channel slot, decoded from address bits [3:2]
  typedef enum logic [1:0] {
    RSEL_CTRL  = 2'd0,
    RSEL_PRESC = 2'd1,
    RSEL_PER   = 2'd2,
    RSEL_DUTY  = 2'd3
  } rsel_e;

  // control bit positions
  localparam int unsigned CB_RUN    = 0;
  localparam int unsigned CB_INV    = 1;
  localparam int unsigned CB_AUTO   = 2;
  localparam int unsigned CB_HALT   = 3;
  localparam int unsigned CB_LDPRE  = 4;
  localparam int unsigned CB_LDPER  = 5;
endpackage

// File: rtl/dpwm_shadow.sv
module dpwm_shadow
  import dpwm_pkg::*;
#(
  parameter int unsigned PRESC_W  = 10,
  parameter int unsigned PER_W    = 12,
  parameter int unsigned SYNC_CYC = 2,
  parameter int unsigned FIELD_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REG_CNT-1:0] wr_sel,
  input  logic [FIELD_W-1:0] wdata,
  output logic [CTRL_W-1:0]  sh_ctrl,
  output logic [PRESC_W-1:0] sh_presc,
  output logic [PER_W-1:0]   sh_per,
  output logic [PER_W-1:0]   sh_duty,
  output logic [CTRL_W-1:0]  xf_ctrl,
  output logic [PRESC_W-1:0] xf_presc,
  output logic [PER_W-1:0]   xf_per,
  output logic [PER_W-1:0]   xf_duty,
  output logic [REG_CNT-1:0] pend,
  output logic               ld_presc,
  output logic               ld_per
);

  localparam int unsigned CNT_W = $clog2(SYNC_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SYNC_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [REG_CNT-1:0] xfer;

  // per-register transfer countdown
  for (genvar r = 0; r < int'(REG_CNT); r++) begin : g_sync
    logic [CNT_W-1:0] c_q, c_d;

    always_comb begin
      c_d = c_q;
      if (wr_sel[r])          c_d = CNT_LOAD;
      else if (c_q != '0)     c_d = c_q - CNT_LAST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) c_q <= '0;
      else        c_q <= c_d;
    end

    assign pend[r] = (c_q != '0);
    assign xfer[r] = (c_q == CNT_LAST) && !wr_sel[r];

    assert_pend_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel[r] |=> pend[r]);
  end

  logic [CTRL_W-1:0]  sh_ctrl_d,  xf_ctrl_d;
  logic [PRESC_W-1:0] sh_presc_d, xf_presc_d;
  logic [PER_W-1:0]   sh_per_d,   xf_per_d;
  logic [PER_W-1:0]   sh_duty_d,  xf_duty_d;
  logic               ld_presc_d, ld_per_d;

  always_comb begin
    sh_ctrl_d  = wr_sel[RSEL_CTRL]  ? wdata[CTRL_W-1:0]  : sh_ctrl;
    sh_presc_d = wr_sel[RSEL_PRESC] ? wdata[PRESC_W-1:0] : sh_presc;
    sh_per_d   = wr_sel[RSEL_PER]   ? wdata[PER_W-1:0]   : sh_per;
    sh_duty_d  = wr_sel[RSEL_DUTY]  ? wdata[PER_W-1:0]   : sh_duty;
    xf_ctrl_d  = xfer[RSEL_CTRL]    ? sh_ctrl            : xf_ctrl;
    xf_presc_d = xfer[RSEL_PRESC]   ? sh_presc           : xf_presc;
    xf_per_d   = xfer[RSEL_PER]     ? sh_per             : xf_per;
    xf_duty_d  = xfer[RSEL_DUTY]    ? sh_duty            : xf_duty;
    ld_presc_d = xfer[RSEL_CTRL] && sh_ctrl[CB_LDPRE];
    ld_per_d   = xfer[RSEL_CTRL] && sh_ctrl[CB_LDPER];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_ctrl  <= '0;
      sh_presc <= '0;
      sh_per   <= '0;
      sh_duty  <= '0;
      xf_ctrl  <= '0;
      xf_presc <= '0;
      xf_per   <= '0;
      xf_duty  <= '0;
      ld_presc <= 1'b0;
      ld_per   <= 1'b0;
    end else begin
      sh_ctrl  <= sh_ctrl_d;
      sh_presc <= sh_presc_d;
      sh_per   <= sh_per_d;
      sh_duty  <= sh_duty_d;
      xf_ctrl  <= xf_ctrl_d;
      xf_presc <= xf_presc_d;
      xf_per   <= xf_per_d;
      xf_duty  <= xf_duty_d;
      ld_presc <= ld_presc_d;
      ld_per   <= ld_per_d;
    end
  end

  // a clearing pending flag means the counting side now holds the written value
  assert_xfer_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend[RSEL_CTRL]) |-> (xf_ctrl == sh_ctrl));
  assert_xfer_presc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend[RSEL_PRESC]) |-> (xf_presc == sh_presc));
  assert_xfer_per_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend[RSEL_PER]) |-> (xf_per == sh_per));
  assert_xfer_duty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend[RSEL_DUTY]) |-> (xf_duty == sh_duty));

endmodule

// File: rtl/dpwm_engine.sv
module dpwm_engine
  import dpwm_pkg::*;
#(
  parameter int unsigned PRESC_W = 10,
  parameter int unsigned PER_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CTRL_W-1:0]  xf_ctrl,
  input  logic [PRESC_W-1:0] xf_presc,
  input  logic [PER_W-1:0]   xf_per,
  input  logic [PER_W-1:0]   xf_duty,
  input  logic               ld_presc,
  input  logic               ld_per,
  output logic               pwm
);

  localparam logic [PRESC_W-1:0] PC_ONE = PRESC_W'(1);
  localparam logic [PER_W-1:0]   CC_ONE = PER_W'(1);

  logic [PRESC_W-1:0] a_presc_q, a_presc_d;
  logic [PER_W-1:0]   a_per_q,   a_per_d;
  logic [PER_W-1:0]   a_duty_q,  a_duty_d;
  logic [PRESC_W-1:0] pc_q, pc_d;
  logic [PER_W-1:0]   cc_q, cc_d;
  logic               run_q, run_d;
  logic               tick, wrap, follow, hi;

  logic unused_ctrl;
  assign unused_ctrl = ^xf_ctrl[CB_LDPER:CB_LDPRE];

  always_comb begin
    tick   = run_q && (pc_q >= a_presc_q);
    wrap   = tick && (cc_q >= a_per_q);
    follow = !xf_ctrl[CB_AUTO] || !run_q;

    a_presc_d = (follow || wrap || ld_presc) ? xf_presc : a_presc_q;
    a_per_d   = (follow || wrap || ld_per)   ? xf_per   : a_per_q;
    a_duty_d  = (follow || wrap)             ? xf_duty  : a_duty_q;

    if (!run_q)
      run_d = xf_ctrl[CB_RUN];
    else if (!xf_ctrl[CB_RUN] && (xf_ctrl[CB_HALT] || wrap))
      run_d = 1'b0;
    else
      run_d = 1'b1;

    if (!run_q || !run_d || tick) pc_d = '0;
    else                          pc_d = pc_q + PC_ONE;

    if (!run_q || !run_d)    cc_d = '0;
    else if (wrap)           cc_d = '0;
    else if (tick)           cc_d = cc_q + CC_ONE;
    else                     cc_d = cc_q;

    hi = (cc_q < a_duty_q) || (a_duty_q >= a_per_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_presc_q <= '0;
      a_per_q   <= '0;
      a_duty_q  <= '0;
      pc_q      <= '0;
      cc_q      <= '0;
      run_q     <= 1'b0;
    end else begin
      a_presc_q <= a_presc_d;
      a_per_q   <= a_per_d;
      a_duty_q  <= a_duty_d;
      pc_q      <= pc_d;
      cc_q      <= cc_d;
      run_q     <= run_d;
    end
  end

  assign pwm = xf_ctrl[CB_INV] ^ (run_q && hi);

  assert_start_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (cc_q == '0) && (pc_q == '0));

  assert_stop_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> ($past(wrap) || $past(xf_ctrl[CB_HALT])));

  assert_halt_next_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !xf_ctrl[CB_RUN] && xf_ctrl[CB_HALT]) |=> !run_q);

  assert_autoload_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && $past(xf_ctrl[CB_AUTO]) && !$past(wrap) && !$past(ld_per))
      |-> $stable(a_per_q));

endmodule

// File: rtl/dual_pwm.sv
module dual_pwm
  import dpwm_pkg::*;
#(
  parameter int unsigned NUM_CH   = 2,
  parameter int unsigned PRESC_W  = 10,
  parameter int unsigned PER_W    = 12,
  parameter int unsigned SYNC_CYC = 2,
  parameter int unsigned AW       = 7,
  parameter int unsigned DW       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  localparam int unsigned FW0     = (PRESC_W > PER_W) ? PRESC_W : PER_W;
  localparam int unsigned FIELD_W = (FW0 > CTRL_W) ? FW0 : CTRL_W;
  localparam int unsigned SLOT_W  = 2;
  localparam logic [AW-1:0] STAT_ADDR = AW'(8'h40);

  function automatic logic [DW-1:0] stat_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int c = 0; c < int'(NUM_CH); c++) m[c*STAT_STRIDE +: REG_CNT] = '1;
    return m;
  endfunction
  localparam logic [DW-1:0] STAT_MASK = stat_mask();

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[DW-1:FIELD_W];

  logic [SLOT_W-1:0] slot;
  rsel_e             rsel;
  logic              stat_hit, ch_hit;

  always_comb begin
    slot     = bus_addr[5:4];
    rsel     = rsel_e'(bus_addr[3:2]);
    stat_hit = (bus_addr == STAT_ADDR);
    ch_hit   = (bus_addr[AW-1:6] == '0) && (bus_addr[1:0] == 2'b00) && (int'(slot) < int'(NUM_CH));
  end

  logic [CTRL_W-1:0]  sh_ctrl  [NUM_CH];
  logic [PRESC_W-1:0] sh_presc [NUM_CH];
  logic [PER_W-1:0]   sh_per   [NUM_CH];
  logic [PER_W-1:0]   sh_duty  [NUM_CH];
  logic [REG_CNT-1:0] pend     [NUM_CH];

  for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
    logic [REG_CNT-1:0] wr_sel;
    logic [CTRL_W-1:0]  xf_ctrl;
    logic [PRESC_W-1:0] xf_presc;
    logic [PER_W-1:0]   xf_per, xf_duty;
    logic               ld_presc, ld_per;

    assign wr_sel = (bus_we && ch_hit && (slot == SLOT_W'(c)))
                  ? (REG_CNT'(1) << rsel) : '0;

    dpwm_shadow #(
      .PRESC_W (PRESC_W),
      .PER_W   (PER_W),
      .SYNC_CYC(SYNC_CYC),
      .FIELD_W (FIELD_W)
    ) u_shadow (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .wr_sel  (wr_sel),
      .wdata   (bus_wdata[FIELD_W-1:0]),
      .sh_ctrl (sh_ctrl[c]),
      .sh_presc(sh_presc[c]),
      .sh_per  (sh_per[c]),
      .sh_duty (sh_duty[c]),
      .xf_ctrl (xf_ctrl),
      .xf_presc(xf_presc),
      .xf_per  (xf_per),
      .xf_duty (xf_duty),
      .pend    (pend[c]),
      .ld_presc(ld_presc),
      .ld_per  (ld_per)
    );

    dpwm_engine #(
      .PRESC_W(PRESC_W),
      .PER_W  (PER_W)
    ) u_engine (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .xf_ctrl (xf_ctrl),
      .xf_presc(xf_presc),
      .xf_per  (xf_per),
      .xf_duty (xf_duty),
      .ld_presc(ld_presc),
      .ld_per  (ld_per),
      .pwm     (pwm_out[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (stat_hit) begin
      for (int c = 0; c < int'(NUM_CH); c++)
        bus_rdata[c*STAT_STRIDE +: REG_CNT] = pend[c];
    end else if (ch_hit) begin
      for (int c = 0; c < int'(NUM_CH); c++) begin
        if (slot == SLOT_W'(c)) begin
          case (rsel)
            RSEL_CTRL:  bus_rdata[CTRL_W-1:0]  = sh_ctrl[c];
            RSEL_PRESC: bus_rdata[PRESC_W-1:0] = sh_presc[c];
            RSEL_PER:   bus_rdata[PER_W-1:0]   = sh_per[c];
            default:    bus_rdata[PER_W-1:0]   = sh_duty[c];
          endcase
        end
      end
    end
  end

  assert_status_clean_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_addr == STAT_ADDR) |-> ((bus_rdata & ~STAT_MASK) == '0));

endmodule

// File: tb/dual_pwm_test.sv
module dual_pwm_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  pwm_out;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  dual_pwm uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pwm_out  (pwm_out)
  );

  typedef struct {
    int    ch;
    int    hi;
    int    per;
    string req;
  } wave_t;
  wave_t sb_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic wait_rise(input int ch, input string req);
    bit prev;
    bit seen;
    seen = 1'b0;
    prev = pwm_out[ch];
    for (int g = 0; g < 1000; g++) begin
      @(negedge clk);
      if (!prev && pwm_out[ch]) begin
        seen = 1'b1;
        break;
      end
      prev = pwm_out[ch];
    end
    if (!seen) check(1'b0, req, 0, 1);
  endtask

  task automatic count_high(input int ch, input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) h++;
    end
  endtask

  // driver side: queue the expected waveform shape
  task automatic expect_wave(input int ch, input int hi, input int per, input string req);
    wave_t w;
    w.ch = ch; w.hi = hi; w.per = per; w.req = req;
    sb_q.push_back(w);
  endtask

  // monitor side: pop each expectation and measure one full period
  task automatic monitor_waves();
    while (sb_q.size() > 0) begin
      wave_t w;
      int    hi_n;
      int    len;
      bit    low_seen;
      w = sb_q.pop_front();
      wait_rise(w.ch, w.req);
      hi_n = 1;
      len = 1;
      low_seen = 1'b0;
      for (int g = 0; g < 2000; g++) begin
        @(negedge clk);
        if (pwm_out[w.ch] && low_seen) break;
        if (!pwm_out[w.ch]) low_seen = 1'b1;
        len++;
        if (pwm_out[w.ch]) hi_n++;
      end
      check_eq({w.req, " high time"}, hi_n, w.hi);
      check_eq({w.req, " period"}, len, w.per);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    int h;
    rst_n = 1'b0;
    bus_we = 1'b0;
    bus_addr = '0;
    bus_wdata = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // reset state
    check_eq("R10 reset idle output", int'(pwm_out), 0);
    rd(7'h40, v); check_eq("R2 reset status", v, 0);
    rd(7'h00, v); check_eq("R1 reset control", v, 0);

    // R1 read-back, field masking, unused slots
    wr(7'h04, 32'hFFFF); rd(7'h04, v); check_eq("R1 prescale mask", v, 32'h3FF);
    wr(7'h08, 32'hFFFF); rd(7'h08, v); check_eq("R1 period mask", v, 32'hFFF);
    wr(7'h0C, 32'h123);  rd(7'h0C, v); check_eq("R1 duty readback", v, 32'h123);
    wr(7'h20, 32'h55);   rd(7'h20, v); check_eq("R1 unused slot", v, 0);
    cyc(4);

    // R2 / R3 pending timing
    wr(7'h04, 32'h1);
    rd(7'h40, v); check_eq("R2 prescale pending set", v, 32'h2);
    cyc(1); rd(7'h40, v); check_eq("R3 pending second cycle", v, 32'h2);
    cyc(1); rd(7'h40, v); check_eq("R3 pending cleared", v, 0);
    wr(7'h18, 32'h7);
    rd(7'h40, v); check_eq("R2 channel 1 shift", v, 32'h400);
    cyc(4);

    // R4 status write ignored
    wr(7'h40, 32'hFFFF_FFFF);
    rd(7'h40, v); check_eq("R4 status write ignored", v, 0);

    // R5 / R12 basic waveforms
    wr(7'h08, 32'd4);
    wr(7'h0C, 32'd2);
    wr(7'h14, 32'd0);
    wr(7'h18, 32'd7);
    wr(7'h1C, 32'd3);
    wr(7'h00, 32'h1);
    wr(7'h10, 32'h1);
    cyc(5);
    expect_wave(0, 4, 10, "R5");
    expect_wave(1, 3, 8, "R12");
    monitor_waves();

    // R7 inversion and inverted idle level
    wr(7'h00, 32'h3);
    cyc(5);
    expect_wave(0, 6, 10, "R7");
    monitor_waves();
    wr(7'h00, 32'hA);
    cyc(5);
    count_high(0, 20, h); check_eq("R7 inverted idle high", h, 20);

    // R6 full on / full off
    wr(7'h0C, 32'd4);
    wr(7'h00, 32'h1);
    cyc(5);
    count_high(0, 40, h); check_eq("R6 duty equals period", h, 40);
    wr(7'h0C, 32'd0);
    cyc(5);
    count_high(0, 40, h); check_eq("R6 duty zero", h, 0);

    // R8 immediate load without autoload
    wr(7'h04, 32'd0);
    wr(7'h08, 32'd99);
    wr(7'h0C, 32'd50);
    cyc(5);
    wait_rise(0, "R8");
    cyc(9);
    wr(7'h0C, 32'd5);
    cyc(7);
    check_eq("R8 immediate duty change", int'(pwm_out[0]), 0);

    // R8 deferred load with autoload
    wr(7'h0C, 32'd50);
    wr(7'h00, 32'h5);
    cyc(5);
    wait_rise(0, "R8");
    cyc(9);
    wr(7'h0C, 32'd5);
    cyc(7);
    check_eq("R8 autoload holds duty", int'(pwm_out[0]), 1);
    expect_wave(0, 5, 100, "R8");
    monitor_waves();

    // R9 forced period load through control bit 5
    wait_rise(0, "R9");
    cyc(9);
    wr(7'h08, 32'd9);
    cyc(3);
    wr(7'h00, 32'h25);
    cyc(5);
    count_high(0, 40, h); check(h > 0, "R9 forced period load", h, 1);
    expect_wave(0, 5, 10, "R9");
    monitor_waves();

    // R10 graceful stop
    wr(7'h08, 32'd99);
    wr(7'h0C, 32'd50);
    wr(7'h00, 32'h5);
    cyc(30);
    wait_rise(0, "R10");
    cyc(4);
    wr(7'h00, 32'h4);
    cyc(30);
    check_eq("R10 period continues", int'(pwm_out[0]), 1);
    cyc(120);
    count_high(0, 200, h); check_eq("R10 idle after period", h, 0);

    // R11 immediate stop
    wr(7'h00, 32'h1);
    wait_rise(0, "R11");
    cyc(5);
    wr(7'h00, 32'h8);
    cyc(2);
    check_eq("R11 still running at transfer", int'(pwm_out[0]), 1);
    cyc(1);
    check_eq("R11 idle after transfer", int'(pwm_out[0]), 0);

    // R12 channel 1 untouched by channel 0 activity
    expect_wave(1, 3, 8, "R12");
    monitor_waves();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule